// File: doc/BRIEF.md
# Prescaled Seconds Timer with Alarm

This block is a free-running up-counter meant for an always-on domain. A slow reference appears as a one-cycle enable strobe. A programmable divider turns that strobe into a periodic tick, and each tick adds one to a counter. With a divide ratio of 32768 and a 32768 Hz reference, the counter advances once per second. Software cannot load the counter. It can only zero it, through a restart bit in the mode register that clears itself.

On every tick the block sets a sticky increment flag. It also compares the new count against a programmed alarm value and sets a sticky alarm flag when the two match. An alarm register holding all ones means no alarm is set, and that value never matches. Reading the status register returns both flags and clears them, unless an event arrives in the same cycle as the read. A single interrupt line is the OR of the flags, each masked by its own enable bit in the mode register.

Access is through a simple single-cycle register port. Read data is combinational during a read cycle. Writes take effect at the clock edge.

Top module: `sec_timer`

## Requirements
- R1: After reset the mode register reads 0x00008000 (divider 32768, both enables off), the value and status registers read 0, and `irq` is low.
- R2: Mode register fields: bits 15:0 hold the divide ratio, bit 16 enables the alarm interrupt, bit 17 enables the increment interrupt, and bit 18 is the restart command. Bit 18 always reads back as 0.
- R3: The counter increases by exactly one after every P cycles in which `slow_en` is high, where P is the divide ratio. Cycles with `slow_en` low have no effect.
- R4: Writes to the value register (0x8) and the status register (0xC) change nothing. Writing 1 to mode bit 18 sets the counter and the divider phase to zero at that clock edge.
- R5: Status bit 1 is set on every tick. Status bit 0 is set on the tick where the counter becomes equal to the alarm register. Both flags are set even when their interrupt enables are off.
- R6: The alarm register resets to all ones. That value means the alarm is disabled, and it never sets the alarm flag.
- R7: A read of the status register returns the two flags and clears them.
- R8: `irq` is high exactly when (status bit 0 AND mode bit 16) OR (status bit 1 AND mode bit 17).
- R9: If a flag is set in the same cycle as a status read, that flag is still set after the read.
- R10: The counter wraps from all ones to zero and sets no extra flag for the wrap.
- R11: A divide ratio of 0 gives one tick every 65536 enabled cycles.
- R12: Register offsets are 0x0 mode, 0x4 alarm, 0x8 value and 0xC status. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | One-cycle strobe for each period of the slow reference |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read cycle |
| irq | output | 1 | Masked interrupt request |

## Verification
The assertions assume that `slow_en` is already synchronous to `clk` and lasts one cycle per reference period. They also assume that every register access completes in one cycle, with no wait states. The bench follows both assumptions: it changes all inputs only on the falling edge and never raises `slow_en` for longer than one cycle per enabled step. The divider is small during most of the run so that the counter can wrap. The counter width is reduced in the bench so that the wrap can be reached in a short run.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;
    // Register offsets (byte addresses)
    localparam logic [3:0] OFS_MODE   = 4'h0;
    localparam logic [3:0] OFS_ALARM  = 4'h4;
    localparam logic [3:0] OFS_VALUE  = 4'h8;
    localparam logic [3:0] OFS_STATUS = 4'hC;

    // Mode register control bit positions
    localparam int B_IE_ALM  = 16;
    localparam int B_IE_INC  = 17;
    localparam int B_RESTART = 18;

    // Status flag positions
    localparam int F_ALM = 0;
    localparam int F_INC = 1;
endpackage

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    localparam int CW = PRE_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_t;

    pre_t s_d, s_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] phase_nx;

    always_comb begin
        // a ratio of zero stands for the full 2**PRE_W range
        limit    = (div == '0) ? {1'b1, {PRE_W{1'b0}}} : {1'b0, div};
        phase_nx = {1'b0, s_q.phase} + CW'(1);
        tick     = en && !restart && (phase_nx >= limit);
        s_d      = s_q;
        if (restart) begin
            s_d.phase = '0;
        end else if (en) begin
            s_d.phase = tick ? '0 : phase_nx[PRE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // restart zeroes the divider phase at the edge (R4)
    p_phase_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.phase == '0));
endmodule

// File: rtl/sec_counter.sv
module sec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] value,
    output logic             alm_hit,
    output logic             inc_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             armed;

    always_comb begin
        cnt_nx  = s_q.cnt + CNT_W'(1);
        armed   = (alarm != '1);
        inc_hit = tick;
        alm_hit = tick && armed && (cnt_nx == alarm);
        s_d     = s_q;
        if (restart)   s_d.cnt = '0;
        else if (tick) s_d.cnt = cnt_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign value = s_q.cnt;

    // one step per tick, wrapping at full scale (R3, R10)
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart) |=> (value == CNT_W'($past(value) + 1'b1)));

    // restart zeroes the count (R4)
    p_count_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (value == '0));

    // without a tick the count holds (R3)
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(value));
endmodule

// File: rtl/sec_status.sv
module sec_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] set,
    input  logic       clr,
    output logic [1:0] flags
);
    typedef struct packed {
        logic [1:0] f;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        // a new event takes priority over a clear in the same cycle
        s_d.f = set | (s_q.f & ~{2{clr}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags = s_q.f;

    p_alarm_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set[0] |=> flags[0]);

    p_inc_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set[1] |=> flags[1]);

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (set == 2'b00)) |=> (flags == 2'b00));
endmodule

// File: rtl/sec_timer.sv
module sec_timer
    import sec_timer_pkg::*;
#(
    parameter int          CNT_W   = 32,
    parameter int          PRE_W   = 16,
    parameter int unsigned PRE_RST = 32768,
    parameter int          ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_ALARM  = ADDR_W'(OFS_ALARM);
    localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFS_VALUE);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    typedef struct packed {
        logic [PRE_W-1:0] div;
        logic             ie_alm;
        logic             ie_inc;
        logic [CNT_W-1:0] alarm;
    } regs_t;

    regs_t            r_d, r_q;
    logic             wr_cyc, rd_cyc, restart, stat_clr;
    logic             tick, alm_hit, inc_hit;
    logic [CNT_W-1:0] value;
    logic [1:0]       flags;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:B_RESTART+1];

    always_comb begin
        wr_cyc   = bus_sel && bus_wr;
        rd_cyc   = bus_sel && !bus_wr;
        restart  = wr_cyc && (bus_addr == A_MODE) && bus_wdata[B_RESTART];
        stat_clr = rd_cyc && (bus_addr == A_STATUS);
        r_d      = r_q;
        if (wr_cyc && (bus_addr == A_MODE)) begin
            r_d.div    = bus_wdata[PRE_W-1:0];
            r_d.ie_alm = bus_wdata[B_IE_ALM];
            r_d.ie_inc = bus_wdata[B_IE_INC];
        end
        if (wr_cyc && (bus_addr == A_ALARM)) begin
            r_d.alarm = bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.div    <= PRE_W'(PRE_RST);
            r_q.ie_alm <= 1'b0;
            r_q.ie_inc <= 1'b0;
            r_q.alarm  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_cyc) begin
            case (bus_addr)
                A_MODE: begin
                    bus_rdata[PRE_W-1:0] = r_q.div;
                    bus_rdata[B_IE_ALM]  = r_q.ie_alm;
                    bus_rdata[B_IE_INC]  = r_q.ie_inc;
                end
                A_ALARM:  bus_rdata[CNT_W-1:0] = r_q.alarm;
                A_VALUE:  bus_rdata[CNT_W-1:0] = value;
                A_STATUS: bus_rdata[1:0]       = flags;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = (flags[F_ALM] && r_q.ie_alm) || (flags[F_INC] && r_q.ie_inc);

    sec_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (slow_en),
        .restart (restart),
        .div     (r_q.div),
        .tick    (tick)
    );

    sec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .alarm   (r_q.alarm),
        .value   (value),
        .alm_hit (alm_hit),
        .inc_hit (inc_hit)
    );

    sec_status u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({inc_hit, alm_hit}),
        .clr   (stat_clr),
        .flags (flags)
    );

    // a disabled alarm never raises the alarm flag (R6)
    p_alarm_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_ALM]) |-> ($past(r_q.alarm) != '1));

    // the restart command is never stored (R2)
    p_no_restart_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cyc && bus_addr == A_MODE) |-> !bus_rdata[B_RESTART]);
endmodule

// File: tb/sec_timer_test.sv
module sec_timer_test;
    localparam int CW = 8;
    localparam int unsigned CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        slow_en, bus_sel, bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq;

    always #5 clk = ~clk;

    sec_timer #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    int          n_run = 0, n_fail = 0;
    logic [15:0] m_div = 16'h8000;
    bit          m_ia = 0, m_ii = 0;
    int unsigned m_alarm = CMAX, m_cnt = 0, m_ph = 0;
    bit   [1:0]  m_flags = 2'b00;
    logic [31:0] last_rd;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'h0:    return {14'b0, m_ii, m_ia, m_div};
            4'h4:    return m_alarm;
            4'h8:    return m_cnt;
            4'hC:    return {30'b0, m_flags};
            default: return 32'h0;
        endcase
    endfunction

    // one clock: drive at the falling edge, compare, then advance the model
    task automatic cyc(input bit s, input bit w, input logic [3:0] a,
                       input logic [31:0] d, input bit e);
        bit rs, rd, tk;
        bit [1:0] set;
        int unsigned lim;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; slow_en = e;
        #1;
        check("R8 irq", {31'b0, irq}, {31'b0, |(m_flags & {m_ii, m_ia})});
        if (s && !w) begin
            last_rd = bus_rdata;
            check("R12 read", bus_rdata, exp_rd(a));
        end
        @(posedge clk);
        rs  = s && w && (a == 4'h0) && d[18];
        rd  = s && !w && (a == 4'hC);
        tk  = 0;
        set = 2'b00;
        lim = (m_div == 0) ? 65536 : m_div;
        if (rs) begin
            m_ph = 0; m_cnt = 0;
        end else if (e) begin
            if (m_ph + 1 >= lim) begin tk = 1; m_ph = 0; end
            else m_ph++;
        end
        if (tk) begin
            m_cnt  = (m_cnt + 1) % (CMAX + 1);
            set[1] = 1;
            if (m_alarm != CMAX && m_cnt == m_alarm) set[0] = 1;
        end
        m_flags = set | (m_flags & (rd ? 2'b00 : 2'b11));
        if (s && w && a == 4'h0) begin m_div = d[15:0]; m_ia = d[16]; m_ii = d[17]; end
        if (s && w && a == 4'h4) m_alarm = d[CW-1:0];
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit e);
        for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, 32'h0, e);
    endtask
    task automatic rdr(input logic [3:0] a);
        cyc(1, 0, a, 32'h0, 0);
    endtask
    task automatic wrr(input logic [3:0] a, input logic [31:0] d);
        cyc(1, 1, a, d, 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; slow_en = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        rdr(4'h0); check("R1 mode reset", last_rd, 32'h0000_8000);
        rdr(4'h4); check("R6 alarm reset", last_rd, CMAX);
        rdr(4'h8); check("R1 value reset", last_rd, 32'h0);
        rdr(4'hC); check("R1 status reset", last_rd, 32'h0);
        rdr(4'h1); check("R12 unmapped read", last_rd, 32'h0);

        wrr(4'h0, (32'h1 << 18) | 32'd3);
        rdr(4'h0); check("R2 restart reads 0", last_rd, 32'd3);
        idle(6, 1);
        rdr(4'h8); check("R3 two ticks at ratio 3", last_rd, 32'd2);
        idle(5, 0);
        rdr(4'h8); check("R3 no count without slow_en", last_rd, 32'd2);

        wrr(4'h8, 32'h12);
        rdr(4'h8); check("R4 value write ignored", last_rd, 32'd2);
        rdr(4'hC); check("R7 status returns inc flag", last_rd, 32'd2);
        rdr(4'hC); check("R7 status cleared", last_rd, 32'd0);
        wrr(4'hC, 32'h3);
        rdr(4'hC); check("R4 status write ignored", last_rd, 32'd0);

        wrr(4'h4, 32'd5);
        idle(9, 1);
        check("R5 no irq with enables off", {31'b0, irq}, 32'h0);
        rdr(4'h8); check("R5 value at alarm", last_rd, 32'd5);
        wrr(4'h0, (32'h1 << 16) | 32'd3);
        check("R8 irq after alarm enable", {31'b0, irq}, 32'h1);
        rdr(4'hC); check("R5 alarm and inc flags", last_rd, 32'd3);
        check("R8 irq drops after clear", {31'b0, irq}, 32'h0);

        wrr(4'h0, 32'd1);
        idle(1, 1);
        cyc(1, 0, 4'hC, 32'h0, 1);
        check("R9 read sees flag", last_rd, 32'd2);
        rdr(4'hC); check("R9 event in read cycle survives", last_rd, 32'd2);
        rdr(4'hC); check("R7 cleared again", last_rd, 32'd0);

        wrr(4'h4, CMAX);
        wrr(4'h0, (32'h1 << 18) | 32'd1);
        idle(300, 1);
        rdr(4'h8); check("R10 wrapped value", last_rd, 32'd44);
        rdr(4'hC); check("R6 no alarm flag when disabled, R10 none on wrap", last_rd, 32'd2);

        wrr(4'h0, (32'h1 << 18));
        idle(65535, 1);
        rdr(4'h8); check("R11 no tick before 65536", last_rd, 32'd0);
        idle(1, 1);
        rdr(4'h8); check("R11 tick at 65536", last_rd, 32'd1);

        finish_run();
    end
endmodule